// File: doc/BRIEF.md
# Buffered SPI word queues with status and interrupt

This block holds the words a serial peripheral controller sends and receives. Two queues sit between the processor bus and the serial shifter. The transmit queue is filled by bus writes and emptied by the shifter. The receive queue is filled by the shifter and emptied by bus reads. Each queue is first-in first-out, holds `DEPTH` words of `DATA_W` bits, and exposes its fill count.

An eight-bit status word summarises both queues and adds two sticky event flags:

- receive overflow, for a word the shifter delivered that found no room;
- transfer complete, raised by the shifter when a burst finishes.

A separately written enable word selects which status bits drive the single interrupt line. Two soft-flush controls empty either queue, or both, in one cycle. Software uses the level flags to decide how many words to move per interrupt, and clears the sticky flags by writing ones.

Each queue tracks its occupancy with a three-state machine:

| State | Meaning |
|---|---|
| `OCC_EMPTY` | no words stored |
| `OCC_PARTIAL` | between one and `DEPTH`-1 words |
| `OCC_FULL` | `DEPTH` words stored |

The occupancy machine moves as follows:

| From | To | Condition |
|---|---|---|
| `OCC_EMPTY` | `OCC_PARTIAL` | first accepted push (fill) |
| `OCC_PARTIAL` | `OCC_FULL` | push that reaches `DEPTH` (top-off) |
| `OCC_PARTIAL` | `OCC_EMPTY` | pop of the last word (drain) |
| `OCC_FULL` | `OCC_PARTIAL` | pop with no push (release) |
| any state | `OCC_EMPTY` | flush |

Each sticky flag is a two-state machine:

| From | To | Condition |
|---|---|---|
| `FLAG_CLEAR` | `FLAG_HELD` | set event (arm) |
| `FLAG_HELD` | `FLAG_CLEAR` | write-one clear with no set in the same cycle (release) |

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset both counts are 0, `irq_en` is 0x00, `irq` is 0, and `status` is 0x01 (only the TX-empty bit set). Read data outputs are 0.
- R2: Each queue returns words in the order they were accepted, and its count rises by one per accepted push and falls by one per accepted pop. The popped word appears on the read data output on the clock edge of the pop and stays there until the next accepted pop.
- R3: Status bit 0 is 1 when the TX count is 0. Bit 1 is 1 when the TX count is at least `DEPTH`/2. Bit 2 is 1 when the TX count equals `DEPTH`.
- R4: Status bit 3 is 1 when the RX count is nonzero. Bit 4 is 1 when the RX count is at least `DEPTH`/2. Bit 5 is 1 when the RX count equals `DEPTH`.
- R5: A push into a full queue with no pop in the same cycle is dropped, and the count is unchanged. A pop from an empty queue leaves the count and the read data unchanged.
- R6: Status bit 6 (overflow) is set when `eng_rx_push` is dropped because the RX queue is full. It stays set until `status_w1c` carries 1 in bit 6. Ones in `status_w1c` bits 0 to 5 have no effect.
- R7: Status bit 7 (transfer complete) is set one edge after `eng_done` is high. It stays set until `status_w1c` carries 1 in bit 7. If a set and a clear occur in the same cycle, the flag is set.
- R8: `irq` is the OR of `status & irq_en`. `irq_en` loads `irq_en_wdata` when `irq_en_wr` is high. An all-zero mask holds `irq` at 0.
- R9: `soft_rst` bit 0 empties the TX queue and bit 1 empties the RX queue, and both may be set together. A flush takes precedence over a push or pop in the same cycle and raises no overflow. Read data and sticky flags are kept.
- R10: A push and a pop in the same cycle are both accepted when the queue is nonempty, including when it is full, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_tx_push | input | 1 | bus writes a word into the TX queue |
| bus_tx_data | input | DATA_W | word to enqueue for transmit |
| bus_rx_pop | input | 1 | bus removes a word from the RX queue |
| bus_rx_data | output | DATA_W | last word removed from the RX queue |
| eng_tx_pop | input | 1 | shifter takes a word from the TX queue |
| eng_tx_data | output | DATA_W | last word removed from the TX queue |
| eng_rx_push | input | 1 | shifter delivers a received word |
| eng_rx_data | input | DATA_W | received word |
| eng_done | input | 1 | burst finished pulse |
| status_w1c | input | 8 | write-one-to-clear mask for status bits 6 and 7 |
| irq_en_wr | input | 1 | load the interrupt enable word |
| irq_en_wdata | input | 8 | new interrupt enable word |
| soft_rst | input | 2 | flush: bit 0 TX, bit 1 RX |
| status | output | 8 | level and event flags |
| irq_en | output | 8 | current interrupt enable word |
| tx_count | output | CNT_W | TX fill count |
| rx_count | output | CNT_W | RX fill count |
| irq | output | 1 | interrupt request |

## Verification
A wrong occupancy state shows at once as a status level bit that disagrees with the count port on the same cycle. It can also show a cycle later as a dropped or duplicated word, visible on the read data ports when that word reaches the head. A wrong sticky flag state shows on status bit 6 or 7, and on `irq` when that bit is enabled. It appears either on the edge after the event or clear that was mishandled, or as a flag that fails to persist across idle cycles. Pointer faults appear only when a word is read back, up to `DEPTH` pops later. For that reason the bench keeps long fill and drain phases.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int ST_W        = 8;
    localparam int ST_TX_EMPTY = 0;
    localparam int ST_TX_HALF  = 1;
    localparam int ST_TX_FULL  = 2;
    localparam int ST_RX_READY = 3;
    localparam int ST_RX_HALF  = 4;
    localparam int ST_RX_FULL  = 5;
    localparam int ST_RX_OVF   = 6;
    localparam int ST_DONE     = 7;
    localparam int N_STICKY    = 2;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_HELD  = 1'b1
    } flag_state_e;

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              half,
    output logic              full
);

    localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] TOP_LVL  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    occ_state_e        state_q, state_nxt;
    logic [CNT_W-1:0]  count_q, count_nxt;
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    assign pop_ok  = pop & ~flush & (state_q != OCC_EMPTY);
    assign push_ok = push & ~flush & ((state_q != OCC_FULL) | pop_ok);

    always_comb begin
        if (flush) begin
            count_nxt = '0;
        end else begin
            count_nxt = count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    // next-state logic of the occupancy machine
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_ok) begin
                    state_nxt = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (flush) begin
                    state_nxt = OCC_EMPTY;
                end else if (push_ok && !pop_ok && count_q == TOP_LVL - CNT_W'(1)) begin
                    state_nxt = OCC_FULL;
                end else if (pop_ok && !push_ok && count_q == CNT_W'(1)) begin
                    state_nxt = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (flush) begin
                    state_nxt = OCC_EMPTY;
                end else if (pop_ok && !push_ok) begin
                    state_nxt = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
                end
            end
            default: state_nxt = OCC_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= OCC_EMPTY;
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            pop_data <= '0;
        end else begin
            state_q <= state_nxt;
            count_q <= count_nxt;
            if (flush) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
            end else begin
                if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
                if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            end
            if (pop_ok) pop_data <= mem[rd_ptr_q];
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr_q] <= push_data;
    end

    // outputs of the occupancy machine
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    full  = 1'b1;
            default:     empty = 1'b1;
        endcase
        half  = (count_q >= HALF_LVL);
        count = count_q;
    end

endmodule

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag
    import spi_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    flag_state_e state_q, state_nxt;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set)         state_nxt = FLAG_HELD;
            FLAG_HELD:  if (clr && !set) state_nxt = FLAG_CLEAR;
            default:                     state_nxt = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_nxt;
    end

    always_comb begin
        unique case (state_q)
            FLAG_HELD:  flag = 1'b1;
            default:    flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tx_push,
    input  logic [DATA_W-1:0] bus_tx_data,
    input  logic              bus_rx_pop,
    output logic [DATA_W-1:0] bus_rx_data,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_done,
    input  logic [ST_W-1:0]   status_w1c,
    input  logic              irq_en_wr,
    input  logic [ST_W-1:0]   irq_en_wdata,
    input  logic [1:0]        soft_rst,
    output logic [ST_W-1:0]   status,
    output logic [ST_W-1:0]   irq_en,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              irq
);

    logic tx_empty, tx_half, tx_full;
    logic rx_empty, rx_half, rx_full;
    logic rx_drop;
    logic [N_STICKY-1:0] sticky_set, sticky_clr, sticky_flag;
    logic unused_w1c;

    assign unused_w1c = ^status_w1c[ST_RX_FULL:ST_TX_EMPTY];

    spi_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst[0]),
        .push      (bus_tx_push),
        .push_data (bus_tx_data),
        .pop       (eng_tx_pop),
        .pop_data  (eng_tx_data),
        .count     (tx_count),
        .empty     (tx_empty),
        .half      (tx_half),
        .full      (tx_full)
    );

    spi_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst[1]),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (bus_rx_pop),
        .pop_data  (bus_rx_data),
        .count     (rx_count),
        .empty     (rx_empty),
        .half      (rx_half),
        .full      (rx_full)
    );

    // a delivered word is lost only when full, not flushing, and not draining
    assign rx_drop = eng_rx_push & ~soft_rst[1] & rx_full & ~(bus_rx_pop & ~rx_empty);

    assign sticky_set = {eng_done, rx_drop};
    assign sticky_clr = {status_w1c[ST_DONE], status_w1c[ST_RX_OVF]};

    for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
        spi_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (sticky_set[g]),
            .clr   (sticky_clr[g]),
            .flag  (sticky_flag[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq_en <= '0;
        else if (irq_en_wr) irq_en <= irq_en_wdata;
    end

    always_comb begin
        status              = '0;
        status[ST_TX_EMPTY] = tx_empty;
        status[ST_TX_HALF]  = tx_half;
        status[ST_TX_FULL]  = tx_full;
        status[ST_RX_READY] = ~rx_empty;
        status[ST_RX_HALF]  = rx_half;
        status[ST_RX_FULL]  = rx_full;
        status[ST_RX_OVF]   = sticky_flag[0];
        status[ST_DONE]     = sticky_flag[1];
    end

    assign irq = |(status & irq_en);

endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       soft_rst,
    input logic             eng_done,
    input logic [7:0]       status_w1c,
    input logic [7:0]       status,
    input logic [7:0]       irq_en,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             irq
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

    // R3
    tx_full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] == (tx_count == TOP));

    // R4
    rx_ready_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] == (rx_count != '0));

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= TOP) && (rx_count <= TOP));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !status_w1c[6]) |=> status[6]);

    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> status[7]);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 8'h00) |-> !irq);

    // R9
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst[0] |=> (tx_count == '0));

    // R10
    tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst[0] |=> ((tx_count == $past(tx_count)) ||
                          (tx_count == $past(tx_count) + CNT_W'(1)) ||
                          (tx_count + CNT_W'(1) == $past(tx_count))));

endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .eng_done   (eng_done),
    .status_w1c (status_w1c),
    .status     (status),
    .irq_en     (irq_en),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .irq        (irq)
);

// File: tb/spi_fifo_irq_bench.sv
module spi_fifo_irq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int DEPTH      = 16;
    localparam int CNT_W      = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_tx_push = 0, bus_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
    logic              eng_done = 0, irq_en_wr = 0;
    logic [DATA_W-1:0] bus_tx_data = '0, eng_rx_data = '0;
    logic [7:0]        status_w1c = '0, irq_en_wdata = '0;
    logic [1:0]        soft_rst = '0;
    logic [DATA_W-1:0] bus_rx_data, eng_tx_data;
    logic [7:0]        status, irq_en;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic              irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [DATA_W-1:0] tx_q[$];
    logic [DATA_W-1:0] rx_q[$];
    logic [DATA_W-1:0] m_tx_rd = '0, m_rx_rd = '0;
    logic              m_ovf = 0, m_done = 0;
    logic [7:0]        m_en = '0;

    spi_fifo_irq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_spi_fifo_irq (
        .clk(clk), .rst_n(rst_n),
        .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data),
        .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_done(eng_done), .status_w1c(status_w1c),
        .irq_en_wr(irq_en_wr), .irq_en_wdata(irq_en_wdata),
        .soft_rst(soft_rst), .status(status), .irq_en(irq_en),
        .tx_count(tx_count), .rx_count(rx_count), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        int ts = tx_q.size();
        int rs = rx_q.size();
        s[0] = (ts == 0);
        s[1] = (ts >= DEPTH / 2);
        s[2] = (ts == DEPTH);
        s[3] = (rs != 0);
        s[4] = (rs >= DEPTH / 2);
        s[5] = (rs == DEPTH);
        s[6] = m_ovf;
        s[7] = m_done;
        return s;
    endfunction

    task automatic model_update();
        int  ts = tx_q.size();
        int  rs = rx_q.size();
        bit  t_pop, t_push, r_pop, r_push, r_drop;
        r_drop = 0;
        if (soft_rst[0]) tx_q.delete();
        else begin
            t_pop  = eng_tx_pop && ts > 0;
            t_push = bus_tx_push && (ts < DEPTH || t_pop);
            if (t_pop)  m_tx_rd = tx_q.pop_front();
            if (t_push) tx_q.push_back(bus_tx_data);
        end
        if (soft_rst[1]) rx_q.delete();
        else begin
            r_pop  = bus_rx_pop && rs > 0;
            r_push = eng_rx_push && (rs < DEPTH || r_pop);
            r_drop = eng_rx_push && !r_push;
            if (r_pop)  m_rx_rd = rx_q.pop_front();
            if (r_push) rx_q.push_back(eng_rx_data);
        end
        m_ovf  = r_drop   | (m_ovf  & ~status_w1c[6]);
        m_done = eng_done | (m_done & ~status_w1c[7]);
        if (irq_en_wr) m_en = irq_en_wdata;
    endtask

    task automatic compare_all();
        logic [7:0] s = exp_status();
        chk("R2", "tx_count", DATA_W'(tx_count), DATA_W'(tx_q.size()));
        chk("R2", "rx_count", DATA_W'(rx_count), DATA_W'(rx_q.size()));
        chk("R2", "eng_tx_data", eng_tx_data, m_tx_rd);
        chk("R2", "bus_rx_data", bus_rx_data, m_rx_rd);
        chk("R3", "tx flags", DATA_W'(status[2:0]), DATA_W'(s[2:0]));
        chk("R4", "rx flags", DATA_W'(status[5:3]), DATA_W'(s[5:3]));
        chk("R6", "overflow", DATA_W'(status[6]), DATA_W'(s[6]));
        chk("R7", "done", DATA_W'(status[7]), DATA_W'(s[7]));
        chk("R8", "irq_en", DATA_W'(irq_en), DATA_W'(m_en));
        chk("R8", "irq", DATA_W'(irq), DATA_W'(|(s & m_en)));
    endtask

    task automatic idle_inputs();
        bus_tx_push = 0; bus_rx_pop = 0; eng_tx_pop = 0; eng_rx_push = 0;
        eng_done = 0; irq_en_wr = 0; status_w1c = '0; soft_rst = '0;
    endtask

    // one clock: inputs held from negedge, model updated at the edge, compared at next negedge
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "status", DATA_W'(status), 32'h01);
        chk("R1", "tx_count", DATA_W'(tx_count), 0);
        chk("R1", "rx_count", DATA_W'(rx_count), 0);
        chk("R1", "irq", DATA_W'(irq), 0);
        chk("R1", "irq_en", DATA_W'(irq_en), 0);
        chk("R1", "bus_rx_data", bus_rx_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 overfill TX: 17 pushes, last one dropped
        for (int i = 0; i < DEPTH + 1; i++) begin
            bus_tx_push = 1; bus_tx_data = 32'hA000_0000 + i; step();
        end
        chk("R5", "tx_count after overfill", DATA_W'(tx_count), DEPTH);
        chk("R3", "tx full bit", DATA_W'(status[2]), 1);

        // R10 push and pop together at full
        bus_tx_push = 1; bus_tx_data = 32'hBEEF_0001; eng_tx_pop = 1; step();
        chk("R10", "tx_count at full push+pop", DATA_W'(tx_count), DEPTH);
        chk("R10", "first word out", eng_tx_data, 32'hA000_0000);

        // drain, then R5 pop from empty keeps last data
        for (int i = 0; i < DEPTH + 2; i++) begin eng_tx_pop = 1; step(); end
        chk("R5", "tx pop empty data", eng_tx_data, 32'hBEEF_0001);
        chk("R3", "tx empty bit", DATA_W'(status[0]), 1);

        // R6 overflow on RX
        for (int i = 0; i < DEPTH + 1; i++) begin
            eng_rx_push = 1; eng_rx_data = 32'hC000_0000 + i; step();
        end
        chk("R6", "overflow set", DATA_W'(status[6]), 1);
        chk("R4", "rx full", DATA_W'(status[5:3]), 3'b111);
        status_w1c = 8'h3F; step();
        chk("R6", "ignored clear bits", DATA_W'(status[6]), 1);

        // R8 enable RX full interrupt, then silence
        irq_en_wr = 1; irq_en_wdata = 8'h20; step();
        chk("R8", "irq on rx full", DATA_W'(irq), 1);
        irq_en_wr = 1; irq_en_wdata = 8'h00; step();
        chk("R8", "irq silenced", DATA_W'(irq), 0);

        status_w1c = 8'h40; step();
        chk("R6", "overflow cleared", DATA_W'(status[6]), 0);

        // R7 set beats clear
        eng_done = 1; status_w1c = 8'h80; step();
        chk("R7", "done set wins", DATA_W'(status[7]), 1);
        step();
        chk("R7", "done held", DATA_W'(status[7]), 1);
        status_w1c = 8'h80; step();
        chk("R7", "done cleared", DATA_W'(status[7]), 0);

        // R9 flush both with simultaneous push, no overflow
        bus_tx_push = 1; eng_rx_push = 1; soft_rst = 2'b11; step();
        chk("R9", "tx flushed", DATA_W'(tx_count), 0);
        chk("R9", "rx flushed", DATA_W'(rx_count), 0);
        chk("R9", "no overflow on flush", DATA_W'(status[6]), 0);
        chk("R9", "rx data kept", bus_rx_data, m_rx_rd);

        // constrained random phases alternating fill and drain bias
        for (int n = 0; n < 4000; n++) begin
            bit fill = ((n / 150) % 2) == 0;
            bus_tx_push = ($urandom % 4) < (fill ? 3 : 1);
            eng_tx_pop  = ($urandom % 4) < (fill ? 1 : 3);
            eng_rx_push = ($urandom % 4) < (fill ? 3 : 1);
            bus_rx_pop  = ($urandom % 4) < (fill ? 1 : 3);
            bus_tx_data = $urandom;
            eng_rx_data = $urandom;
            eng_done    = ($urandom % 16) == 0;
            status_w1c  = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
            irq_en_wr   = ($urandom % 32) == 0;
            irq_en_wdata = 8'($urandom);
            soft_rst    = (($urandom % 64) == 0) ? 2'($urandom) : 2'b00;
            step();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule